// File: doc/BRIEF.md
# Wrapping Stack Pointer Unit

This block keeps the stack pointer for a small 8-bit processor core and supplies the byte address for each stack access. The stack lives in a fixed 64-byte window from 0x00C0 to 0x00FF. Only the low six bits of the address are held in a register. The upper ten bits are a constant prefix, so the address can never leave the window. The pointer always names the next free location. A push writes there and then moves the pointer down. A pull first moves the pointer up and then reads the location it now names.

The processor sequencer drives one strobe per command. Single-byte push and pull take one cycle. The reset-stack-pointer command reloads the top of the window and produces no memory access. Frame commands issue one byte per clock until the whole frame is done: subroutine entry writes 2 bytes, interrupt entry writes 5 bytes, subroutine return reads 2 bytes and interrupt return reads 5 bytes. While the remaining bytes of a frame go out, `busy_o` is high and every new strobe is ignored. Running past 64 locations wraps the pointer without any fault, and older stack contents are overwritten.

Top module: `stk_ptr_unit`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge) the pointer is 0x3F: `wr_o`, `rd_o` and `busy_o` are 0, and the next push writes 0x00FF.
- R2: An accepted push raises `wr_o` in that same cycle, with `addr_o` equal to the current pointer address. At the clock edge the pointer drops by one.
- R3: An accepted pull raises `rd_o` in that same cycle, with `addr_o` equal to the pointer address plus one. At the clock edge the pointer rises by one.
- R4: `addr_o` is always the ten-bit prefix 0000000011 followed by the six pointer bits, so every access falls within 0x00C0..0x00FF.
- R5: The pointer wraps without a fault. A push at 0x00C0 is followed by a push at 0x00FF. A pull with the pointer at 0x3F reads 0x00C0.
- R6: The reset-stack-pointer strobe sets the pointer to 0x3F and produces no `wr_o` or `rd_o` in its cycle.
- R7: A call strobe issues two writes on consecutive cycles at descending addresses. `busy_o` is 0 in the first cycle and 1 in the second.
- R8: An interrupt strobe issues five writes on consecutive cycles at descending addresses. `busy_o` is 1 for the last four of them.
- R9: A return strobe issues two reads and an interrupt-return strobe issues five reads, one per cycle at ascending addresses. `busy_o` is high after the first read of each.
- R10: While `busy_o` is 1, every strobe is ignored. The frame continues unchanged and the pointer afterwards is the same as with no strobe.
- R11: When several strobes are high in an idle cycle, only one is taken, in this order: reset-stack-pointer, interrupt, call, interrupt-return, return, push, pull.
- R12: In an idle cycle with no strobe, `wr_o` and `rd_o` are 0 and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push one byte |
| pull_i | input | 1 | Pull one byte |
| rsp_i | input | 1 | Reload the pointer to the top of the window |
| call_i | input | 1 | Push a 2-byte subroutine frame |
| irq_i | input | 1 | Push a 5-byte interrupt frame |
| ret_i | input | 1 | Pull a 2-byte subroutine frame |
| rti_i | input | 1 | Pull a 5-byte interrupt frame |
| addr_o | output | 16 | Stack memory address for this cycle |
| wr_o | output | 1 | Stack write in this cycle |
| rd_o | output | 1 | Stack read in this cycle |
| busy_o | output | 1 | Frame in progress; strobes are ignored |

## Verification
The hardest case to reach is the wrap of a frame across the bottom of the window, where an interrupt frame begins a few bytes above 0x00C0 and its later bytes land back at 0x00FF. The bench first walks the pointer down with single pushes to a known position near the bottom, keeping its own model of the pointer, and then starts the five-byte frame so that the wrap happens in the middle of it. Strobes that arrive while busy are driven during the tail cycles of the frames, and their lack of effect is checked by the addresses the frame and the next access then use.

// File: rtl/stk_pkg.sv
// Shared types for the stack pointer unit.
// Assumes: one command enters per idle cycle; the order of the values carries no meaning.
package stk_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RSP,
        CMD_PUSH,
        CMD_PULL,
        CMD_CALL,
        CMD_IRQ,
        CMD_RET,
        CMD_RTI
    } stk_cmd_e;
endpackage

// File: rtl/stk_cmd_sel.sv
// Picks one command from the strobes when the unit is idle.
// Assumes: strobes are level inputs sampled once per cycle; all of them are ignored while busy.
module stk_cmd_sel
    import stk_pkg::*;
(
    input  logic     busy,
    input  logic     rsp,
    input  logic     irq,
    input  logic     call,
    input  logic     rti,
    input  logic     ret,
    input  logic     push,
    input  logic     pull,
    output stk_cmd_e cmd
);
    // Fixed priority select: rsp, irq, call, rti, ret, push, pull.
    always_comb begin
        cmd = CMD_NONE;
        if (!busy) begin
            if (rsp)       cmd = CMD_RSP;
            else if (irq)  cmd = CMD_IRQ;
            else if (call) cmd = CMD_CALL;
            else if (rti)  cmd = CMD_RTI;
            else if (ret)  cmd = CMD_RET;
            else if (push) cmd = CMD_PUSH;
            else if (pull) cmd = CMD_PULL;
        end
    end
endmodule

// File: rtl/stk_frame_seq.sv
// Issues one byte step per clock for single and multi-byte frames.
// Assumes: a frame's direction is fixed when it starts; busy covers the bytes after the first.
module stk_frame_seq
    import stk_pkg::*;
#(
    parameter int CALL_LEN = 2,
    parameter int IRQ_LEN  = 5,
    localparam int MAX_LEN = (IRQ_LEN > CALL_LEN) ? IRQ_LEN : CALL_LEN,
    localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  stk_cmd_e cmd,
    output logic     step,
    output logic     step_push,
    output logic     rsp_load,
    output logic     busy
);
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             dir_q, dir_d;

    assign busy = (rem_q != '0);

    // Next-state: continue an open frame or start the selected command.
    always_comb begin
        step      = 1'b0;
        step_push = dir_q;
        rsp_load  = 1'b0;
        rem_d     = rem_q;
        dir_d     = dir_q;
        if (rem_q != '0) begin
            step  = 1'b1;
            rem_d = rem_q - CNT_W'(1);
        end else begin
            unique case (cmd)
                CMD_RSP:  rsp_load = 1'b1;
                CMD_PUSH: begin step = 1'b1; step_push = 1'b1; end
                CMD_PULL: begin step = 1'b1; step_push = 1'b0; end
                CMD_CALL: begin
                    step = 1'b1; step_push = 1'b1;
                    dir_d = 1'b1; rem_d = CNT_W'(CALL_LEN - 1);
                end
                CMD_IRQ: begin
                    step = 1'b1; step_push = 1'b1;
                    dir_d = 1'b1; rem_d = CNT_W'(IRQ_LEN - 1);
                end
                CMD_RET: begin
                    step = 1'b1; step_push = 1'b0;
                    dir_d = 1'b0; rem_d = CNT_W'(CALL_LEN - 1);
                end
                CMD_RTI: begin
                    step = 1'b1; step_push = 1'b0;
                    dir_d = 1'b0; rem_d = CNT_W'(IRQ_LEN - 1);
                end
                default: ;
            endcase
        end
    end

    // Frame state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dir_q <= 1'b1;
        end else begin
            rem_q <= rem_d;
            dir_q <= dir_d;
        end
    end
endmodule

// File: rtl/stk_ptr_reg.sv
// Holds the wrapping pointer and gives the low address bits of the current access.
// Assumes: a push uses the pointer then decrements; a pull increments then uses the new value.
module stk_ptr_reg #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             step_push,
    input  logic             rsp_load,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] acc_low
);
    localparam logic [PTR_W-1:0] PTR_TOP = '1;
    logic [PTR_W-1:0] ptr_up;

    // Modulo increment; wraps from the top of the window to its bottom.
    assign ptr_up  = ptr_q + PTR_W'(1);
    // Low address bits: the pointer for a write, the incremented pointer for a read.
    assign acc_low = step_push ? ptr_q : ptr_up;

    // Pointer update: reload, decrement on push, increment on pull.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr_q <= PTR_TOP;
        else if (rsp_load)         ptr_q <= PTR_TOP;
        else if (step && step_push) ptr_q <= ptr_q - PTR_W'(1);
        else if (step)             ptr_q <= ptr_up;
    end
endmodule

// File: rtl/stk_ptr_unit.sv
// Top of the stack pointer unit: command select, frame sequencer, pointer, address.
// Assumes: the stack window is aligned to its size; the address is combinational from the strobes.
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 PTR_W    = 6,
    parameter logic [ADDR_W-1:0]  BASE     = 16'h00C0,
    parameter int                 CALL_LEN = 2,
    parameter int                 IRQ_LEN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pull_i,
    input  logic              rsp_i,
    input  logic              call_i,
    input  logic              irq_i,
    input  logic              ret_i,
    input  logic              rti_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic              busy_o
);
    localparam int PFX_W = ADDR_W - PTR_W;
    localparam logic [PFX_W-1:0] PREFIX = BASE[ADDR_W-1:PTR_W];

    stk_cmd_e         cmd;
    logic             step, step_push, rsp_load, busy;
    logic [PTR_W-1:0] ptr_q, acc_low;

    stk_cmd_sel u_sel (
        .busy (busy),   .rsp (rsp_i),  .irq (irq_i),   .call (call_i),
        .rti  (rti_i),  .ret (ret_i),  .push (push_i), .pull (pull_i),
        .cmd  (cmd)
    );

    stk_frame_seq #(.CALL_LEN(CALL_LEN), .IRQ_LEN(IRQ_LEN)) u_seq (
        .clk (clk), .rst_n (rst_n), .cmd (cmd),
        .step (step), .step_push (step_push), .rsp_load (rsp_load), .busy (busy)
    );

    stk_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk (clk), .rst_n (rst_n), .step (step), .step_push (step_push),
        .rsp_load (rsp_load), .ptr_q (ptr_q), .acc_low (acc_low)
    );

    // Output assembly: fixed prefix above the pointer bits, strobes by direction.
    assign addr_o = {PREFIX, acc_low};
    assign wr_o   = step &  step_push;
    assign rd_o   = step & ~step_push;
    assign busy_o = busy;
endmodule

// File: rtl/stk_ptr_chk.sv
// Property checker for the stack pointer unit, bound to every instance of the top.
// Assumes: the pointer width is small enough to compare directly.
module stk_ptr_chk #(
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pull_i,
    input logic              rsp_i,
    input logic              call_i,
    input logic              irq_i,
    input logic              ret_i,
    input logic              rti_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              wr_o,
    input logic              rd_o,
    input logic              busy_o,
    input logic [PTR_W-1:0]  ptr
);
    logic any_cmd;
    assign any_cmd = push_i | pull_i | rsp_i | call_i | irq_i | ret_i | rti_i;

    // R2: a write moves the pointer down by one.
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> ptr == PTR_W'($past(ptr) - PTR_W'(1)));

    // R3: a read moves the pointer up by one.
    assert_pull_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

    // R4: a write uses the address of the pointer itself.
    assert_wr_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> addr_o[PTR_W-1:0] == ptr);

    // R6: an accepted reload lands at the top of the window.
    assert_rsp_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && rsp_i) |=> ptr == '1);

    // R7: an accepted call opens a frame whose next byte is also a write.
    assert_call_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && call_i && !rsp_i && !irq_i) |=> (busy_o && wr_o));

    // R9: an accepted return opens a frame whose next byte is also a read.
    assert_ret_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && ret_i && !rsp_i && !irq_i && !call_i && !rti_i) |=> (busy_o && rd_o));

    // R10: while busy, every cycle moves a byte.
    assert_busy_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $countones({wr_o, rd_o}) == 1);

    // R12: an idle cycle with no strobe leaves the pointer unchanged.
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !any_cmd) |=> $stable(ptr));

    // R12: never a write and a read together.
    assert_one_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o, rd_o}));
endmodule

bind stk_ptr_unit stk_ptr_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .push_i (push_i), .pull_i (pull_i),
    .rsp_i (rsp_i), .call_i (call_i), .irq_i (irq_i), .ret_i (ret_i),
    .rti_i (rti_i), .addr_o (addr_o), .wr_o (wr_o), .rd_o (rd_o),
    .busy_o (busy_o), .ptr (ptr_q)
);

// File: tb/sim_stk_ptr_unit.sv
`timescale 1ns/1ps
// Directed bench for the stack pointer unit; one task per scenario, with its own pointer model.
module sim_stk_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pull_i = 0, rsp_i = 0, call_i = 0, irq_i = 0, ret_i = 0, rti_i = 0;
    logic [15:0] addr_o;
    logic        wr_o, rd_o, busy_o;

    int n_chk  = 0;
    int n_fail = 0;
    int mptr   = 63;
    bit done   = 0;

    always #2.5 clk = ~clk;

    stk_ptr_unit u0 (
        .clk (clk), .rst_n (rst_n), .push_i (push_i), .pull_i (pull_i),
        .rsp_i (rsp_i), .call_i (call_i), .irq_i (irq_i), .ret_i (ret_i),
        .rti_i (rti_i), .addr_o (addr_o), .wr_o (wr_o), .rd_o (rd_o), .busy_o (busy_o)
    );

    function automatic logic [15:0] wa(input int p);
        return 16'h00C0 | 16'(p & 63);
    endfunction

    task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got wr/rd/busy/addr %h expected %h", req, act, exp);
        end
    endtask

    // Drive strobes {rsp,irq,call,rti,ret,push,pull} for one cycle and check outputs.
    task automatic cyc(input logic [6:0] s, input logic ew, input logic er,
                       input logic [15:0] ea, input logic eb, input string req);
        @(negedge clk);
        {rsp_i, irq_i, call_i, rti_i, ret_i, push_i, pull_i} = s;
        #1;
        if (ew || er) chk(req, {wr_o, rd_o, busy_o, addr_o}, {ew, er, eb, ea});
        else          chk(req, {wr_o, rd_o, busy_o, 16'h0}, {ew, er, eb, 16'h0});
        @(posedge clk);
        #0.5;
        {rsp_i, irq_i, call_i, rti_i, ret_i, push_i, pull_i} = '0;
    endtask

    task automatic do_push(input string req);
        cyc(7'b0000010, 1, 0, wa(mptr), 0, req);
        mptr = (mptr - 1) & 63;
    endtask

    task automatic do_pull(input string req);
        mptr = (mptr + 1) & 63;
        cyc(7'b0000001, 0, 1, wa(mptr), 0, req);
    endtask

    // R1: reset state and first push address.
    task automatic t_reset;
        rst_n = 0;
        repeat (2) @(posedge clk);
        #0.5 rst_n = 1;
        mptr = 63;
        cyc(7'b0, 0, 0, 16'h0, 0, "R1");
        chk("R1", {3'b000, wa(mptr)}, {3'b000, 16'h00FF});
        do_push("R1");
        do_pull("R1");
    endtask

    // R2 R3 R4: push then pull sequences.
    task automatic t_push_pull;
        for (int i = 0; i < 3; i++) do_push("R2");
        for (int i = 0; i < 2; i++) do_pull("R3");
        do_push("R4");
        for (int i = 0; i < 2; i++) do_pull("R3");
    endtask

    // R5: wrap at both ends of the window.
    task automatic t_wrap;
        for (int i = 0; i < 64; i++) do_push("R5");
        cyc(7'b0000010, 1, 0, 16'h00FF, 0, "R5");
        mptr = 62;
        do_pull("R5");
        cyc(7'b0000001, 0, 1, 16'h00C0, 0, "R5");
        mptr = 0;
        do_push("R5");
        chk("R5", {3'b0, wa(mptr)}, {3'b0, 16'h00FF});
    endtask

    // R6 R12: reload and idle hold.
    task automatic t_rsp;
        do_push("R6"); do_push("R6");
        cyc(7'b1000000, 0, 0, 16'h0, 0, "R6");
        mptr = 63;
        cyc(7'b0, 0, 0, 16'h0, 0, "R12");
        cyc(7'b0, 0, 0, 16'h0, 0, "R12");
        do_push("R6");
        do_pull("R12");
    endtask

    // R7 R8 R9: call, interrupt and returns.
    task automatic t_frames;
        int p0;
        p0 = mptr;
        cyc(7'b0010000, 1, 0, wa(p0), 0, "R7");
        cyc(7'b0000000, 1, 0, wa(p0 - 1), 1, "R7");
        mptr = (p0 - 2) & 63;
        p0 = mptr;
        cyc(7'b0100000, 1, 0, wa(p0), 0, "R8");
        for (int i = 1; i < 5; i++) cyc(7'b0, 1, 0, wa(p0 - i), 1, "R8");
        mptr = (p0 - 5) & 63;
        cyc(7'b0, 0, 0, 16'h0, 0, "R8");
        p0 = mptr;
        cyc(7'b0001000, 0, 1, wa(p0 + 1), 0, "R9");
        for (int i = 2; i <= 5; i++) cyc(7'b0, 0, 1, wa(p0 + i), 1, "R9");
        mptr = (p0 + 5) & 63;
        p0 = mptr;
        cyc(7'b0000100, 0, 1, wa(p0 + 1), 0, "R9");
        cyc(7'b0, 0, 1, wa(p0 + 2), 1, "R9");
        mptr = (p0 + 2) & 63;
        cyc(7'b0, 0, 0, 16'h0, 0, "R9");
    endtask

    // R10 R5: strobes during a busy interrupt frame that wraps at the bottom.
    task automatic t_busy;
        cyc(7'b1000000, 0, 0, 16'h0, 0, "R10");
        mptr = 63;
        for (int i = 0; i < 62; i++) do_push("R10");
        cyc(7'b0100000, 1, 0, wa(1), 0, "R10");
        cyc(7'b1000000, 1, 0, wa(0), 1, "R10");
        cyc(7'b0000001, 1, 0, 16'h00FF, 1, "R10");
        cyc(7'b0010000, 1, 0, wa(62), 1, "R10");
        cyc(7'b0000010, 1, 0, wa(61), 1, "R10");
        mptr = 60;
        do_push("R10");
        do_pull("R10");
    endtask

    // R11: simultaneous strobes.
    task automatic t_prio;
        do_push("R11");
        cyc(7'b1000010, 0, 0, 16'h0, 0, "R11");
        mptr = 63;
        cyc(7'b0110000, 1, 0, wa(63), 0, "R11");
        for (int i = 1; i < 5; i++) cyc(7'b0, 1, 0, wa(63 - i), 1, "R11");
        mptr = 58;
        cyc(7'b0001100, 0, 1, wa(59), 0, "R11");
        for (int i = 2; i <= 5; i++) cyc(7'b0, 0, 1, wa(58 + i), 1, "R11");
        mptr = 63;
        cyc(7'b0000011, 1, 0, wa(63), 0, "R11");
        mptr = 62;
        do_pull("R11");
    endtask

    initial begin
        t_reset;
        t_push_pull;
        t_wrap;
        t_rsp;
        t_frames;
        t_busy;
        t_prio;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule